// File: doc/BRIEF.md
# Low-Power Mode Step Sequencer

This block takes the CPU platform from RUN into a programmed low-power mode (WAIT, STOP or SUSPEND) and back again. A sleep event starts a chain of six power-management steps in a fixed order. A wakeup starts the same six steps in the reverse order. Each step is a request/done handshake with an external agent. A per-step counter decides when the step is complete: on done alone, on done followed by a counted delay, on the count alone, or on whichever of done and the count comes first.

Wakeup can come from any unmasked interrupt line, from one event input and from one debug wakeup request. Each source has a mask bit and a sticky status bit. Software picks the target mode and can enable chip standby for each low-power mode. While a standby-enabled sequence runs, a busy flag is raised for it. The behaviour of the step agents is outside this block.

Top module: `lp_step_seq`

## Requirements
- R1: After reset, `step_req` is 0, `mode_cur` and `mode_prev` are 0 (RUN), both busy flags are 0 and all wakeup status bits are 0.
- R2: The mode encoding is 0 RUN, 1 WAIT, 2 STOP, 3 SUSPEND. When `cfg_target_mode` is 0, a sleep event starts no sequence and the mode stays RUN.
- R3: `cpu_wfi` is always a sleep event. `cpu_wfe` is a sleep event only while `cfg_wfe_en` is 1. The first step request is visible in the cycle after the edge that samples the event.
- R4: `step_req` has one bit per step (bit i is step i: 0 save, 1 clock gate, 2 PLL, 3 isolation, 4 reset, 5 power). At most one bit is high at a time. The sleep sequence visits steps 0 to 5 in ascending order.
- R5: While the sleep sequence runs, `mode_cur` stays RUN. On the edge that finishes the last step, `mode_cur` takes the target latched at sleep start and `mode_prev` becomes RUN.
- R6: Step mode is given by `cfg_step_mode[2i+1:2i]`. In mode 0 a step completes in the cycle its done is high. In mode 2, done is ignored and the request stays high for limit+1 cycles.
- R7: In mode 1, a step completes `limit` cycles after the cycle in which done is first high. In mode 3, it completes on done or after limit+1 request cycles, whichever comes first.
- R8: An interrupt line, the event input or the debug request sets its status bit only while its mask bit is 0 (1 masks it) and the block is outside RUN. Any set status bit in low-power mode starts the wakeup sequence two cycles after the source is first sampled. Statuses clear when a sleep sequence starts.
- R9: A step with its `cfg_step_skip` bit set raises no request and costs one idle cycle.
- R10: The wakeup sequence visits steps 5 down to 0. When it finishes, `mode_cur` becomes RUN and `mode_prev` takes the low-power mode that was left.
- R11: A wakeup seen during the sleep sequence does not cut it short. The sleep sequence finishes, and the wakeup sequence follows.
- R12: `cfg_stby_en` bit 0, 1 or 2 enables standby for WAIT, STOP or SUSPEND. `stby_sleep_busy` is high in every sleep-sequence cycle, and `stby_wake_busy` in every wakeup-sequence cycle, only when standby is enabled for the target mode.
- R13: The step counter restarts at zero for every step, so consecutive counted steps each take their full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_target_mode | input | 2 | Low-power mode to enter on the next sleep event |
| cfg_wfe_en | input | 1 | Lets `cpu_wfe` act as a sleep event |
| cfg_stby_en | input | 3 | Standby enable for WAIT, STOP, SUSPEND |
| cfg_step_mode | input | 2*NUM_STEPS | Completion mode of each step |
| cfg_step_limit | input | CNT_W*NUM_STEPS | Count limit of each step |
| cfg_step_skip | input | NUM_STEPS | Skip bit of each step |
| cpu_wfi | input | 1 | Wait-for-interrupt sleep event |
| cpu_wfe | input | 1 | Wait-for-event sleep event |
| irq_in | input | NUM_IRQ | Interrupt lines |
| irq_mask | input | NUM_IRQ | Wakeup mask per interrupt line, 1 masks |
| evt_in | input | 1 | Event wakeup source |
| evt_mask | input | 1 | Mask for `evt_in` |
| dbg_wake_in | input | 1 | Debug wakeup request |
| dbg_mask | input | 1 | Mask for `dbg_wake_in` |
| step_done | input | NUM_STEPS | Done response from each step agent |
| step_req | output | NUM_STEPS | Request to each step agent |
| mode_cur | output | 2 | Current CPU mode |
| mode_prev | output | 2 | Previous CPU mode |
| irq_wake_stat | output | NUM_IRQ | Sticky interrupt wakeup status |
| evt_wake_stat | output | 1 | Sticky event wakeup status |
| dbg_wake_stat | output | 1 | Sticky debug wakeup status |
| stby_sleep_busy | output | 1 | Standby entry in progress |
| stby_wake_busy | output | 1 | Standby exit in progress |

## Verification
After the edge that samples a sleep event, the first request appears one cycle later. Each step then holds its request for a number of cycles set by its mode and limit. A skipped step leaves one empty cycle, and the mode outputs change on the edge that closes the last step. A wakeup source reaches its status bit one cycle after it is sampled and the first wakeup request one cycle after that. The bench drives inputs on the falling edge and samples outputs on the falling edge. A logger records every request run with its step and length, so each duration is compared with limit arithmetic worked out in the bench. The wakeup latency is checked at exactly the first and second falling edge after the stimulus.

// File: rtl/lp_seq_pkg.sv
`timescale 1ns/1ps
package lp_seq_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_SLEEP = 2'd1, ST_LOW = 2'd2, ST_WAKE = 2'd3} seq_state_e;

  localparam logic [1:0] CM_DONE   = 2'd0;
  localparam logic [1:0] CM_DELAY  = 2'd1;
  localparam logic [1:0] CM_COUNT  = 2'd2;
  localparam logic [1:0] CM_EITHER = 2'd3;

  localparam logic [1:0] MODE_RUN = 2'd0;

  // standby enable bit that belongs to a low-power mode
  function automatic logic stby_pick(input logic [1:0] tgt, input logic [2:0] en);
    case (tgt)
      2'd1:    return en[0];
      2'd2:    return en[1];
      2'd3:    return en[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lp_wake_collect.sv
`timescale 1ns/1ps
module lp_wake_collect #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               arm,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               evt_in,
  input  logic               evt_mask,
  input  logic               dbg_in,
  input  logic               dbg_mask,
  output logic [NUM_IRQ-1:0] irq_stat,
  output logic               evt_stat,
  output logic               dbg_stat,
  output logic               wake_any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stat <= '0;
      evt_stat <= 1'b0;
      dbg_stat <= 1'b0;
    end else if (clr) begin
      irq_stat <= '0;
      evt_stat <= 1'b0;
      dbg_stat <= 1'b0;
    end else if (arm) begin
      irq_stat <= irq_stat | (irq_in & ~irq_mask);
      evt_stat <= evt_stat | (evt_in & ~evt_mask);
      dbg_stat <= dbg_stat | (dbg_in & ~dbg_mask);
    end
  end

  assign wake_any = (|irq_stat) | evt_stat | dbg_stat;
endmodule

// File: rtl/lp_step_timer.sv
`timescale 1ns/1ps
module lp_step_timer
  import lp_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] limit,
  input  logic             done,
  output logic             fin,
  output logic [CNT_W-1:0] cnt
);
  logic seen;
  logic hit;

  // completion rule for one cycle of an active step
  function automatic logic step_complete(input logic [1:0] m, input logic d, input logic s,
                                         input logic h, input logic lim_zero);
    case (m)
      CM_DONE:   return d;
      CM_DELAY:  return s ? h : (d && lim_zero);
      CM_COUNT:  return h;
      default:   return d || h;
    endcase
  endfunction

  assign hit = (cnt == limit);
  assign fin = active && step_complete(mode, done, seen, hit, limit == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (!active || fin) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      case (mode)
        CM_DELAY: begin
          if (seen) begin
            cnt <= cnt + 1'b1;
          end else if (done) begin
            seen <= 1'b1;
            cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end
        CM_COUNT, CM_EITHER: cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/lp_step_seq.sv
`timescale 1ns/1ps
module lp_step_seq
  import lp_seq_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int CNT_W     = 16,
  parameter int NUM_STEPS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cfg_target_mode,
  input  logic                       cfg_wfe_en,
  input  logic [2:0]                 cfg_stby_en,
  input  logic [NUM_STEPS*2-1:0]     cfg_step_mode,
  input  logic [NUM_STEPS*CNT_W-1:0] cfg_step_limit,
  input  logic [NUM_STEPS-1:0]       cfg_step_skip,
  input  logic                       cpu_wfi,
  input  logic                       cpu_wfe,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic [NUM_IRQ-1:0]         irq_mask,
  input  logic                       evt_in,
  input  logic                       evt_mask,
  input  logic                       dbg_wake_in,
  input  logic                       dbg_mask,
  input  logic [NUM_STEPS-1:0]       step_done,
  output logic [NUM_STEPS-1:0]       step_req,
  output logic [1:0]                 mode_cur,
  output logic [1:0]                 mode_prev,
  output logic [NUM_IRQ-1:0]         irq_wake_stat,
  output logic                       evt_wake_stat,
  output logic                       dbg_wake_stat,
  output logic                       stby_sleep_busy,
  output logic                       stby_wake_busy
);
  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state;
  logic [STEP_W-1:0] pos;
  logic [1:0]        tgt_q;
  logic              stby_q;
  logic [1:0]        mode_cur_q;
  logic [1:0]        mode_prev_q;

  // named internal events, also watched by the checker
  logic              run_idle;
  logic              seq_active;
  logic              sleep_go;
  logic              wake_go;
  logic              step_run;
  logic              step_fin;
  logic              seq_done;
  logic              wake_any;
  logic              tmr_fin;
  logic [CNT_W-1:0]  tmr_cnt;
  logic [STEP_W-1:0] cur_step;
  logic [1:0]        cur_mode;
  logic [CNT_W-1:0]  cur_lim;
  logic              cur_skip;
  logic              cur_done;

  // step visited at a position: ascending on the way down, descending on the way up
  function automatic logic [STEP_W-1:0] step_at(input logic [STEP_W-1:0] p, input logic waking);
    return waking ? (LAST - p) : p;
  endfunction

  assign run_idle   = (state == ST_RUN);
  assign seq_active = (state == ST_SLEEP) || (state == ST_WAKE);
  assign cur_step   = step_at(pos, state == ST_WAKE);
  assign cur_mode   = cfg_step_mode[cur_step*2 +: 2];
  assign cur_lim    = cfg_step_limit[cur_step*CNT_W +: CNT_W];
  assign cur_skip   = cfg_step_skip[cur_step];
  assign cur_done   = step_done[cur_step];

  assign step_run = seq_active && !cur_skip;
  assign step_fin = seq_active && (cur_skip || tmr_fin);
  assign seq_done = step_fin && (pos == LAST);
  assign sleep_go = run_idle && (cpu_wfi || (cpu_wfe && cfg_wfe_en)) &&
                    (cfg_target_mode != MODE_RUN);
  assign wake_go  = (state == ST_LOW) && wake_any;

  lp_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (step_run),
    .mode   (cur_mode),
    .limit  (cur_lim),
    .done   (cur_done),
    .fin    (tmr_fin),
    .cnt    (tmr_cnt)
  );

  lp_wake_collect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sleep_go),
    .arm      (!run_idle),
    .irq_in   (irq_in),
    .irq_mask (irq_mask),
    .evt_in   (evt_in),
    .evt_mask (evt_mask),
    .dbg_in   (dbg_wake_in),
    .dbg_mask (dbg_mask),
    .irq_stat (irq_wake_stat),
    .evt_stat (evt_wake_stat),
    .dbg_stat (dbg_wake_stat),
    .wake_any (wake_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      pos         <= '0;
      tgt_q       <= MODE_RUN;
      stby_q      <= 1'b0;
      mode_cur_q  <= MODE_RUN;
      mode_prev_q <= MODE_RUN;
    end else begin
      case (state)
        ST_RUN: if (sleep_go) begin
          state  <= ST_SLEEP;
          pos    <= '0;
          tgt_q  <= cfg_target_mode;
          stby_q <= stby_pick(cfg_target_mode, cfg_stby_en);
        end
        ST_SLEEP: if (step_fin) begin
          if (seq_done) begin
            state       <= ST_LOW;
            pos         <= '0;
            mode_prev_q <= mode_cur_q;
            mode_cur_q  <= tgt_q;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_LOW: if (wake_go) begin
          state <= ST_WAKE;
          pos   <= '0;
        end
        default: if (step_fin) begin
          if (seq_done) begin
            state       <= ST_RUN;
            pos         <= '0;
            mode_prev_q <= mode_cur_q;
            mode_cur_q  <= MODE_RUN;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_req
    assign step_req[g] = step_run && (cur_step == STEP_W'(g));
  end

  assign mode_cur        = mode_cur_q;
  assign mode_prev       = mode_prev_q;
  assign stby_sleep_busy = (state == ST_SLEEP) && stby_q;
  assign stby_wake_busy  = (state == ST_WAKE) && stby_q;
endmodule

// File: rtl/lp_step_seq_chk.sv
`timescale 1ns/1ps
module lp_step_seq_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_STEPS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_STEPS-1:0] step_req,
  input logic [NUM_STEPS-1:0] cfg_step_skip,
  input logic [1:0]           cfg_target_mode,
  input logic [1:0]           mode_cur,
  input logic [1:0]           mode_prev,
  input logic                 run_idle,
  input logic                 seq_active,
  input logic                 seq_done,
  input logic                 step_run,
  input logic [1:0]           cur_mode,
  input logic [CNT_W-1:0]     cur_lim,
  input logic [CNT_W-1:0]     tmr_cnt,
  input logic                 stby_sleep_busy,
  input logic                 stby_wake_busy
);
  a_r4_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_req));

  a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req & cfg_step_skip) == '0);

  a_r2_run_target_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_idle && cfg_target_mode == 2'd0) |=> (step_req == '0 && mode_cur == 2'd0));

  a_r5_mode_steady_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !seq_done) |=> ($stable(mode_cur) && $stable(mode_prev)));

  a_r10_prev_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prev != $past(mode_prev)) |-> $past(seq_done));

  a_r13_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (step_run && cur_mode != 2'd0) |-> (tmr_cnt <= cur_lim));

  a_r12_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stby_sleep_busy && stby_wake_busy));

  a_r12_sleep_busy_in_run_mode: assert property (@(posedge clk) disable iff (!rst_n)
    stby_sleep_busy |-> (mode_cur == 2'd0));

  a_r12_wake_busy_in_low_mode: assert property (@(posedge clk) disable iff (!rst_n)
    stby_wake_busy |-> (mode_cur != 2'd0));
endmodule

bind lp_step_seq lp_step_seq_chk #(.CNT_W(CNT_W), .NUM_STEPS(NUM_STEPS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .step_req        (step_req),
  .cfg_step_skip   (cfg_step_skip),
  .cfg_target_mode (cfg_target_mode),
  .mode_cur        (mode_cur),
  .mode_prev       (mode_prev),
  .run_idle        (run_idle),
  .seq_active      (seq_active),
  .seq_done        (seq_done),
  .step_run        (step_run),
  .cur_mode        (cur_mode),
  .cur_lim         (cur_lim),
  .tmr_cnt         (tmr_cnt),
  .stby_sleep_busy (stby_sleep_busy),
  .stby_wake_busy  (stby_wake_busy)
);

// File: tb/tb_lp_step_seq.sv
`timescale 1ns/1ps
module tb_lp_step_seq;
  localparam int NI = 32;
  localparam int CW = 16;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_target_mode = 2'd2;
  logic cfg_wfe_en = 1'b0;
  logic [2:0] cfg_stby_en = 3'b010;
  logic [NS*2-1:0] cfg_step_mode = '0;
  logic [NS*CW-1:0] cfg_step_limit = '0;
  logic [NS-1:0] cfg_step_skip = '0;
  logic cpu_wfi = 1'b0, cpu_wfe = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [NI-1:0] irq_mask = ~(NI'(1) << 3);
  logic evt_in = 1'b0, evt_mask = 1'b0, dbg_wake_in = 1'b0, dbg_mask = 1'b0;
  logic [NS-1:0] done_en = '1;
  logic [NS-1:0] step_done;
  logic [NS-1:0] step_req;
  logic [1:0] mode_cur, mode_prev;
  logic [NI-1:0] irq_wake_stat;
  logic evt_wake_stat, dbg_wake_stat, stby_sleep_busy, stby_wake_busy;

  int n_chk = 0;
  int n_fail = 0;
  int n_ent;
  int ent_step [32];
  int ent_len [32];
  int sb_cyc, wb_cyc;
  logic [NS-1:0] last_req;

  assign step_done = step_req & done_en;

  always #5 clk = ~clk;

  lp_step_seq #(.NUM_IRQ(NI), .CNT_W(CW), .NUM_STEPS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_target_mode(cfg_target_mode), .cfg_wfe_en(cfg_wfe_en),
    .cfg_stby_en(cfg_stby_en), .cfg_step_mode(cfg_step_mode), .cfg_step_limit(cfg_step_limit),
    .cfg_step_skip(cfg_step_skip), .cpu_wfi(cpu_wfi), .cpu_wfe(cpu_wfe), .irq_in(irq_in),
    .irq_mask(irq_mask), .evt_in(evt_in), .evt_mask(evt_mask), .dbg_wake_in(dbg_wake_in),
    .dbg_mask(dbg_mask), .step_done(step_done), .step_req(step_req), .mode_cur(mode_cur),
    .mode_prev(mode_prev), .irq_wake_stat(irq_wake_stat), .evt_wake_stat(evt_wake_stat),
    .dbg_wake_stat(dbg_wake_stat), .stby_sleep_busy(stby_sleep_busy),
    .stby_wake_busy(stby_wake_busy)
  );

  function automatic int idx_of(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  // request-run logger, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_req != '0) begin
        if (step_req != last_req && n_ent < 32) begin
          ent_step[n_ent] = idx_of(step_req);
          ent_len[n_ent] = 1;
          n_ent = n_ent + 1;
        end else if (n_ent > 0) begin
          ent_len[n_ent-1] = ent_len[n_ent-1] + 1;
        end
      end
      if (stby_sleep_busy) sb_cyc = sb_cyc + 1;
      if (stby_wake_busy) wb_cyc = wb_cyc + 1;
      last_req = step_req;
    end
  end

  task automatic clear_log();
    n_ent = 0; sb_cyc = 0; wb_cyc = 0; last_req = '0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_step(input int i, input logic [1:0] m, input int lim, input logic skip);
    cfg_step_mode[i*2 +: 2] = m;
    cfg_step_limit[i*CW +: CW] = CW'(lim);
    cfg_step_skip[i] = skip;
  endtask

  task automatic plain_steps();
    for (int i = 0; i < NS; i++) set_step(i, 2'd0, 0, 1'b0);
    done_en = '1;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); cpu_wfi = 1'b1;
    @(negedge clk); cpu_wfi = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    chk("R1", "step_req", int'(step_req), 0);
    chk("R1", "mode_cur", int'(mode_cur), 0);
    chk("R1", "mode_prev", int'(mode_prev), 0);
    chk("R1", "busy", int'({stby_sleep_busy, stby_wake_busy}), 0);
    chk("R1", "wake stat", int'(irq_wake_stat != '0) + int'(evt_wake_stat) + int'(dbg_wake_stat), 0);
  endtask

  // R2
  task automatic t_run_target();
    cfg_target_mode = 2'd0;
    clear_log();
    pulse_wfi();
    wait_cyc(10);
    chk("R2", "requests with RUN target", n_ent, 0);
    chk("R2", "mode_cur", int'(mode_cur), 0);
    cfg_target_mode = 2'd2;
  endtask

  // R3 R4 R5 R12
  task automatic t_sleep_order();
    cfg_wfe_en = 1'b0;
    clear_log();
    @(negedge clk); cpu_wfe = 1'b1;
    @(negedge clk); cpu_wfe = 1'b0;
    wait_cyc(10);
    chk("R3", "requests from gated wfe", n_ent, 0);
    cfg_wfe_en = 1'b1;
    clear_log();
    @(negedge clk); cpu_wfe = 1'b1;
    @(negedge clk); cpu_wfe = 1'b0;
    chk("R3", "first request latency", int'(step_req), 1);
    chk("R5", "mode_cur during sleep", int'(mode_cur), 0);
    wait_cyc(10);
    cfg_wfe_en = 1'b0;
    chk("R4", "sleep entries", n_ent, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R4", "sleep step order", ent_step[i], i);
      chk("R6", "mode-0 step length", ent_len[i], 1);
    end
    chk("R5", "mode_cur after sleep", int'(mode_cur), 2);
    chk("R5", "mode_prev after sleep", int'(mode_prev), 0);
    chk("R12", "sleep busy cycles", sb_cyc, 6);
  endtask

  // R8 R10 R12
  task automatic t_wake_irq();
    clear_log();
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    chk("R8", "no request one cycle after source", int'(step_req), 0);
    chk("R8", "irq status", int'(irq_wake_stat == (NI'(1) << 3)), 1);
    @(negedge clk);
    chk("R10", "first wake request", int'(step_req), 32);
    wait_cyc(10);
    chk("R10", "wake entries", n_ent, 6);
    for (int i = 0; i < 6; i++) chk("R10", "wake step order", ent_step[i], 5 - i);
    chk("R10", "mode_cur after wake", int'(mode_cur), 0);
    chk("R10", "mode_prev after wake", int'(mode_prev), 2);
    chk("R12", "wake busy cycles", wb_cyc, 6);
  endtask

  // R5 R8 R12
  task automatic t_masked();
    cfg_target_mode = 2'd3;
    pulse_wfi();
    wait_cyc(10);
    chk("R8", "statuses cleared at sleep start", int'(irq_wake_stat != '0), 0);
    chk("R5", "suspend mode", int'(mode_cur), 3);
    chk("R12", "no busy when mode standby off", sb_cyc, 0);
    clear_log();
    @(negedge clk); irq_in[4] = 1'b1; evt_mask = 1'b1; evt_in = 1'b1;
    wait_cyc(15);
    chk("R8", "masked sources no wake", n_ent, 0);
    chk("R8", "mode held", int'(mode_cur), 3);
    chk("R8", "masked statuses", int'(irq_wake_stat != '0) + int'(evt_wake_stat), 0);
    irq_in[4] = 1'b0; evt_in = 1'b0; evt_mask = 1'b0;
    @(negedge clk); dbg_wake_in = 1'b1;
    @(negedge clk); dbg_wake_in = 1'b0;
    wait_cyc(10);
    chk("R8", "debug status", int'(dbg_wake_stat), 1);
    chk("R10", "mode_prev after suspend", int'(mode_prev), 3);
    chk("R10", "mode_cur back to run", int'(mode_cur), 0);
    cfg_target_mode = 2'd2;
  endtask

  // R6 R7 R9 R13
  task automatic t_modes();
    cfg_target_mode = 2'd1;
    set_step(0, 2'd0, 0, 1'b0);
    set_step(1, 2'd2, 4, 1'b0);
    set_step(2, 2'd3, 3, 1'b0);
    set_step(3, 2'd3, 10, 1'b0);
    set_step(4, 2'd1, 3, 1'b0);
    set_step(5, 2'd0, 0, 1'b1);
    done_en = 6'b111011;
    clear_log();
    pulse_wfi();
    wait_cyc(30);
    chk("R9", "entries with skip", n_ent, 5);
    chk("R6", "mode 0", ent_len[0], 1);
    chk("R6", "mode 2 ignores done", ent_len[1], 5);
    chk("R7", "mode 3 timeout", ent_len[2], 4);
    chk("R7", "mode 3 done first", ent_len[3], 1);
    chk("R7", "mode 1 delay", ent_len[4], 4);
    chk("R13", "counted steps back to back", ent_len[1] + ent_len[2], 9);
    chk("R5", "wait mode", int'(mode_cur), 1);
    clear_log();
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    wait_cyc(30);
    chk("R9", "wake entries with skip", n_ent, 5);
    chk("R9", "first wake step", ent_step[0], 4);
    chk("R7", "wake mode 1", ent_len[0], 4);
    chk("R13", "wake mode 2", ent_len[3], 5);
    chk("R10", "back to run", int'(mode_cur), 0);
    plain_steps();
    cfg_target_mode = 2'd2;
  endtask

  // R11
  task automatic t_wake_in_sleep();
    set_step(0, 2'd2, 20, 1'b0);
    clear_log();
    pulse_wfi();
    wait_cyc(3);
    evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
    wait_cyc(60);
    chk("R11", "entries", n_ent, 12);
    chk("R11", "long first step kept", ent_len[0], 21);
    for (int i = 0; i < 6; i++) begin
      chk("R11", "sleep order", ent_step[i], i);
      chk("R11", "wake order", ent_step[6+i], 5 - i);
    end
    chk("R11", "event status", int'(evt_wake_stat), 1);
    chk("R11", "mode_prev", int'(mode_prev), 2);
    chk("R11", "mode_cur", int'(mode_cur), 0);
    plain_steps();
  endtask

  initial begin
    plain_steps();
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_target();
    t_sleep_order();
    t_wake_irq();
    t_masked();
    t_modes();
    t_wake_in_sleep();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule